// File: doc/BRIEF.md
# Timer Compare Output Channel

This block is one output-compare channel of a general-purpose timer. The counter value and its direction come in from outside, together with an update-event strobe and a trigger-input edge pulse. From these the channel builds a single registered reference level that later stages (polarity, dead time, pin muxing) consume. The channel can be frozen, forced low or high, set, cleared or toggled when the counter equals the compare value, or run as a PWM generator in either polarity. The PWM comparison takes the count direction into account.

Configuration arrives through single-cycle write strobes. The compare value can be written straight into the active comparator or through a shadow copy that only moves across on an update event. A trigger edge in a PWM mode is treated as a forced compare match with a latency of 3 or 5 clock edges, chosen by a fast-trigger enable. The channel I/O selection and a protection level gate which configuration writes are accepted.

Top module: `tcc_chan`

## Requirements
- R1: After reset `ref_out` is 0, the active and shadow compare values are 0, the compare mode is frozen (000), the I/O selection is output (00), and shadow and fast enables are clear.
- R2: Mode 100 drives `ref_out` to 0 and mode 101 drives it to 1 on the next clock edge, whatever the counter does.
- R3: Mode 000 (frozen) keeps `ref_out` at its previous level.
- R4: On an edge where the counter equals the active compare value, mode 001 sets `ref_out`, mode 010 clears it and mode 011 inverts it. On other edges these modes hold the output.
- R5: Mode 110 (PWM0) makes the comparison 1 when counting up (`cnt_down`=0) with counter < compare, and when counting down with counter <= compare. Otherwise the comparison is 0.
- R6: Mode 111 (PWM1) gives the inverse of the PWM0 comparison in both directions.
- R7: In a PWM mode `ref_out` loads the comparison only when the comparison differs from its value on the previous edge, or on the first edge after entering PWM from a non-PWM mode. Otherwise it holds, including after a forced trigger level.
- R8: With shadow enable set, a compare write only updates the shadow copy, and the active value loads the shadow on an update event. With shadow enable clear, a write updates both copies. The new active value first affects `ref_out` on the edge after the one that loaded it.
- R9: In a PWM mode, a `trig_edge` pulse sampled on edge k forces `ref_out` to its compare level (0 for PWM0, 1 for PWM1) on edge k+2 when fast enable is set, and on edge k+4 when it is clear.
- R10: While the I/O selection is 01, 10 or 11 (input), `ref_out` is 0 and trigger edges have no effect.
- R11: A write of the I/O selection is ignored while `chan_en` is 1.
- R12: When `prot_lvl` is 11 and the I/O selection is 00, a control write does not change the compare mode or the shadow enable. The fast enable is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Running counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| upd_evt | input | 1 | Update-event strobe |
| trig_edge | input | 1 | One-cycle pulse for an active trigger-input edge |
| chan_en | input | 1 | Channel enable; blocks I/O selection writes |
| prot_lvl | input | 2 | Protection level; 11 locks mode and shadow enable |
| wr_ctl | input | 1 | Control write strobe |
| ctl_mode | input | 3 | Compare mode to write |
| ctl_shadow_en | input | 1 | Shadow enable to write |
| ctl_fast_en | input | 1 | Fast-trigger enable to write |
| wr_iosel | input | 1 | I/O selection write strobe |
| iosel_in | input | 2 | I/O selection to write (00 output, else input) |
| wr_cv | input | 1 | Compare value write strobe |
| cv_in | input | CNT_W | Compare value to write |
| ref_out | output | 1 | Registered reference output |

## Verification
The bench aims at the direction-dependent boundary where the counter equals the compare value. A design that used the same strict comparison in both directions would drop the output one edge early when counting down. The trigger pulse is timed edge by edge at both latencies, which exposes an off-by-one tap or a force that wins only when the comparison already agrees. After a forced level it holds the counter still, so that a channel which reloads the comparison every edge would wipe the forced level at once. It also writes the compare value with shadow on, with and without an update event. Finally it makes blocked control and I/O writes and then shows, through the output level, that the old setting still holds.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        OC_FROZEN = 3'b000,
        OC_SET    = 3'b001,
        OC_CLR    = 3'b010,
        OC_TOG    = 3'b011,
        OC_LOW    = 3'b100,
        OC_HIGH   = 3'b101,
        OC_PWM0   = 3'b110,
        OC_PWM1   = 3'b111
    } oc_mode_e;

    typedef enum logic [1:0] {
        IO_OUT    = 2'b00,
        IO_IN_A   = 2'b01,
        IO_IN_B   = 2'b10,
        IO_IN_TRG = 2'b11
    } io_sel_e;

    typedef struct packed {
        oc_mode_e mode;
        logic     shadow_en;
        logic     fast_en;
        io_sel_e  io;
    } cfg_t;

    localparam logic [1:0] PROT_FULL = 2'b11;

endpackage

// File: rtl/tcc_cfg_regs.sv
module tcc_cfg_regs
    import tcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic [1:0] prot_lvl,
    input  logic       wr_ctl,
    input  logic [2:0] ctl_mode,
    input  logic       ctl_shadow_en,
    input  logic       ctl_fast_en,
    input  logic       wr_iosel,
    input  logic [1:0] iosel_in,
    output cfg_t       cfg
);

    cfg_t cfg_d, cfg_q;
    logic locked;

    always_comb begin
        cfg_d  = cfg_q;
        locked = (prot_lvl == PROT_FULL) && (cfg_q.io == IO_OUT);
        if (wr_ctl) begin
            cfg_d.fast_en = ctl_fast_en;
            if (!locked) begin
                cfg_d.mode      = oc_mode_e'(ctl_mode);
                cfg_d.shadow_en = ctl_shadow_en;
            end
        end
        if (wr_iosel && !chan_en) begin
            cfg_d.io = io_sel_e'(iosel_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: OC_FROZEN, shadow_en: 1'b0, fast_en: 1'b0, io: IO_OUT};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/tcc_cv_regs.sv
module tcc_cv_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cv,
    input  logic [CNT_W-1:0] cv_in,
    input  logic             upd_evt,
    input  logic             shadow_en,
    output logic [CNT_W-1:0] cv_act,
    output logic [CNT_W-1:0] cv_shadow
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] act;
    } cv_state_t;

    cv_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_cv) begin
            st_d.shadow = cv_in;
            if (!shadow_en) begin
                st_d.act = cv_in;
            end
        end
        if (shadow_en && upd_evt) begin
            st_d.act = st_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cv_act    = st_q.act;
    assign cv_shadow = st_q.shadow;

endmodule

// File: rtl/tcc_trig_pipe.sv
module tcc_trig_pipe #(
    parameter int FAST_LAT = 3,
    parameter int SLOW_LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    input  logic fast_en,
    output logic trig_hit
);

    localparam int DEPTH    = SLOW_LAT - 1;
    localparam int FAST_TAP = FAST_LAT - 2;
    localparam int SLOW_TAP = SLOW_LAT - 2;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = trig_in;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign trig_hit = fast_en ? pipe_q[FAST_TAP] : pipe_q[SLOW_TAP];

endmodule

// File: rtl/tcc_out_logic.sv
module tcc_out_logic
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] cv_act,
    input  logic             trig_hit,
    output logic             ref_out
);

    typedef struct packed {
        logic lvl;
        logic raw;
        logic was_pwm;
    } out_state_t;

    out_state_t st_d, st_q;
    logic below, raw, eq, pwm, cmp_lvl;

    always_comb begin
        below   = cnt_down ? (cnt_val <= cv_act) : (cnt_val < cv_act);
        raw     = (cfg.mode == OC_PWM1) ? ~below : below;
        eq      = (cnt_val == cv_act);
        pwm     = (cfg.mode == OC_PWM0) || (cfg.mode == OC_PWM1);
        cmp_lvl = (cfg.mode == OC_PWM1);

        st_d         = st_q;
        st_d.raw     = raw;
        st_d.was_pwm = pwm && (cfg.io == IO_OUT);

        if (cfg.io != IO_OUT) begin
            st_d.lvl = 1'b0;
        end else begin
            case (cfg.mode)
                OC_FROZEN: st_d.lvl = st_q.lvl;
                OC_SET:    if (eq) st_d.lvl = 1'b1;
                OC_CLR:    if (eq) st_d.lvl = 1'b0;
                OC_TOG:    if (eq) st_d.lvl = ~st_q.lvl;
                OC_LOW:    st_d.lvl = 1'b0;
                OC_HIGH:   st_d.lvl = 1'b1;
                OC_PWM0, OC_PWM1: begin
                    if (trig_hit) begin
                        st_d.lvl = cmp_lvl;
                    end else if (!st_q.was_pwm || (raw != st_q.raw)) begin
                        st_d.lvl = raw;
                    end
                end
                default:   st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_out = st_q.lvl;

endmodule

// File: rtl/tcc_chan.sv
module tcc_chan
    import tcc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int FAST_LAT = 3,
    parameter int SLOW_LAT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_down,
    input  logic             upd_evt,
    input  logic             trig_edge,
    input  logic             chan_en,
    input  logic [1:0]       prot_lvl,
    input  logic             wr_ctl,
    input  logic [2:0]       ctl_mode,
    input  logic             ctl_shadow_en,
    input  logic             ctl_fast_en,
    input  logic             wr_iosel,
    input  logic [1:0]       iosel_in,
    input  logic             wr_cv,
    input  logic [CNT_W-1:0] cv_in,
    output logic             ref_out
);

    cfg_t             cfg;
    logic [CNT_W-1:0] cv_act_w;
    logic [CNT_W-1:0] cv_shadow_w;
    logic             trig_hit;
    logic [2:0]       mode_w;
    logic [1:0]       io_w;
    logic             shadow_en_w;

    assign mode_w      = cfg.mode;
    assign io_w        = cfg.io;
    assign shadow_en_w = cfg.shadow_en;

    tcc_cfg_regs u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .chan_en       (chan_en),
        .prot_lvl      (prot_lvl),
        .wr_ctl        (wr_ctl),
        .ctl_mode      (ctl_mode),
        .ctl_shadow_en (ctl_shadow_en),
        .ctl_fast_en   (ctl_fast_en),
        .wr_iosel      (wr_iosel),
        .iosel_in      (iosel_in),
        .cfg           (cfg)
    );

    tcc_cv_regs #(.CNT_W(CNT_W)) u_cv (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cv     (wr_cv),
        .cv_in     (cv_in),
        .upd_evt   (upd_evt),
        .shadow_en (cfg.shadow_en),
        .cv_act    (cv_act_w),
        .cv_shadow (cv_shadow_w)
    );

    tcc_trig_pipe #(.FAST_LAT(FAST_LAT), .SLOW_LAT(SLOW_LAT)) u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_edge),
        .fast_en  (cfg.fast_en),
        .trig_hit (trig_hit)
    );

    tcc_out_logic #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_val  (cnt_val),
        .cnt_down (cnt_down),
        .cfg      (cfg),
        .cv_act   (cv_act_w),
        .trig_hit (trig_hit),
        .ref_out  (ref_out)
    );

endmodule

// File: rtl/tcc_chan_chk.sv
module tcc_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_out,
    input logic [2:0]       mode_w,
    input logic [1:0]       io_w,
    input logic             shadow_en_w,
    input logic             chan_en,
    input logic [1:0]       prot_lvl,
    input logic             wr_ctl,
    input logic             wr_iosel,
    input logic             upd_evt,
    input logic [CNT_W-1:0] cv_act,
    input logic [CNT_W-1:0] cv_shadow
);

    p_force_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == 3'b101 && io_w == 2'b00) |=> ref_out);

    p_force_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_w == 3'b100) |=> !ref_out);

    p_input_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_w != 2'b00) |=> !ref_out);

    p_io_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_iosel && chan_en) |=> $stable(io_w));

    p_prot_lock_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && prot_lvl == 2'b11 && io_w == 2'b00) |=> ($stable(mode_w) && $stable(shadow_en_w)));

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en_w && !upd_evt) |=> $stable(cv_act));

    p_shadow_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en_w && upd_evt) |=> (cv_act == $past(cv_shadow)));

endmodule

bind tcc_chan tcc_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_out     (ref_out),
    .mode_w      (mode_w),
    .io_w        (io_w),
    .shadow_en_w (shadow_en_w),
    .chan_en     (chan_en),
    .prot_lvl    (prot_lvl),
    .wr_ctl      (wr_ctl),
    .wr_iosel    (wr_iosel),
    .upd_evt     (upd_evt),
    .cv_act      (cv_act_w),
    .cv_shadow   (cv_shadow_w)
);

// File: tb/tcc_chan_bench.sv
module tcc_chan_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_down = 1'b0;
    logic         upd_evt = 1'b0;
    logic         trig_edge = 1'b0;
    logic         chan_en = 1'b0;
    logic [1:0]   prot_lvl = 2'b00;
    logic         wr_ctl = 1'b0;
    logic [2:0]   ctl_mode = 3'b000;
    logic         ctl_shadow_en = 1'b0;
    logic         ctl_fast_en = 1'b0;
    logic         wr_iosel = 1'b0;
    logic [1:0]   iosel_in = 2'b00;
    logic         wr_cv = 1'b0;
    logic [W-1:0] cv_in = '0;
    logic         ref_out;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    string cur_tag = "R1";

    // reference model state
    logic [2:0]   m_mode;
    logic         m_sh, m_fast, m_ref, m_raw, m_wp;
    logic [1:0]   m_io;
    logic [W-1:0] m_shd, m_act;
    logic [3:0]   m_pipe;

    always #2.5 clk = ~clk;

    tcc_chan #(.CNT_W(W)) u_tcc_chan (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .trig_edge(trig_edge), .chan_en(chan_en),
        .prot_lvl(prot_lvl), .wr_ctl(wr_ctl), .ctl_mode(ctl_mode),
        .ctl_shadow_en(ctl_shadow_en), .ctl_fast_en(ctl_fast_en),
        .wr_iosel(wr_iosel), .iosel_in(iosel_in), .wr_cv(wr_cv),
        .cv_in(cv_in), .ref_out(ref_out)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic pwm_cmp(input logic [2:0] mode, input logic [W-1:0] c,
                                     input logic dn, input logic [W-1:0] cv);
        logic below;
        below = dn ? (c <= cv) : (c < cv);
        return (mode == 3'b111) ? !below : below;
    endfunction

    task automatic model_reset();
        m_mode = 3'b000; m_sh = 0; m_fast = 0; m_io = 2'b00;
        m_shd = '0; m_act = '0; m_pipe = '0; m_ref = 0; m_raw = 0; m_wp = 0;
    endtask

    task automatic model_step();
        logic lock, hit, pwm, nraw, nref, eqv;
        logic [2:0] nm; logic nsh, nf; logic [1:0] nio;
        logic [W-1:0] nshd, nact;
        lock = (prot_lvl == 2'b11) && (m_io == 2'b00);
        nm = m_mode; nsh = m_sh; nf = m_fast; nio = m_io;
        if (wr_ctl) begin
            nf = ctl_fast_en;
            if (!lock) begin nm = ctl_mode; nsh = ctl_shadow_en; end
        end
        if (wr_iosel && !chan_en) nio = iosel_in;
        nshd = m_shd; nact = m_act;
        if (wr_cv) begin nshd = cv_in; if (!m_sh) nact = cv_in; end
        if (m_sh && upd_evt) nact = m_shd;
        hit  = m_fast ? m_pipe[1] : m_pipe[3];
        pwm  = (m_mode[2:1] == 2'b11);
        nraw = pwm_cmp(m_mode, cnt_val, cnt_down, m_act);
        eqv  = (cnt_val == m_act);
        nref = m_ref;
        if (m_io != 2'b00) nref = 1'b0;
        else begin
            case (m_mode)
                3'b001: if (eqv) nref = 1'b1;
                3'b010: if (eqv) nref = 1'b0;
                3'b011: if (eqv) nref = !m_ref;
                3'b100: nref = 1'b0;
                3'b101: nref = 1'b1;
                3'b110, 3'b111: begin
                    if (hit) nref = (m_mode == 3'b111);
                    else if (!m_wp || nraw != m_raw) nref = nraw;
                end
                default: nref = m_ref;
            endcase
        end
        m_wp = pwm && (m_io == 2'b00);
        m_raw = nraw; m_ref = nref;
        m_pipe = {m_pipe[2:0], trig_edge};
        m_mode = nm; m_sh = nsh; m_fast = nf; m_io = nio; m_shd = nshd; m_act = nact;
    endtask

    // one clock: inputs already driven; check model after edge, clear strobes
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(ref_out, m_ref, cur_tag);
        wr_ctl = 0; wr_iosel = 0; wr_cv = 0; upd_evt = 0; trig_edge = 0;
    endtask

    task automatic set_ctl(input logic [2:0] md, input logic sh, input logic fe);
        wr_ctl = 1; ctl_mode = md; ctl_shadow_en = sh; ctl_fast_en = fe;
        cycle();
    endtask

    task automatic set_cv(input logic [W-1:0] v);
        wr_cv = 1; cv_in = v;
        cycle();
    endtask

    task automatic set_io(input logic [1:0] v);
        wr_iosel = 1; iosel_in = v;
        cycle();
    endtask

    task automatic at_cnt(input logic [W-1:0] c, input logic dn);
        cnt_val = c; cnt_down = dn;
        cycle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_tag = "R1";
        chk(ref_out, 1'b0, "R1 reset level");
        set_ctl(3'b110, 0, 0);          // PWM0 with reset compare 0
        at_cnt(16'd0, 0);
        chk(ref_out, 1'b0, "R1 compare value zero after reset");

        // R2: forced levels
        cur_tag = "R2";
        set_ctl(3'b101, 0, 0);
        at_cnt(16'd7, 0);
        chk(ref_out, 1'b1, "R2 force high");
        set_ctl(3'b100, 0, 0);
        at_cnt(16'd3, 1);
        chk(ref_out, 1'b0, "R2 force low");

        // R3: frozen holds
        cur_tag = "R3";
        set_ctl(3'b101, 0, 0);
        set_ctl(3'b000, 0, 0);
        at_cnt(16'd0, 0);
        at_cnt(16'd9, 1);
        chk(ref_out, 1'b1, "R3 frozen keeps high");

        // R4: match modes
        cur_tag = "R4";
        set_cv(16'd10);
        set_ctl(3'b100, 0, 0);
        set_ctl(3'b001, 0, 0);
        at_cnt(16'd9, 0);
        chk(ref_out, 1'b0, "R4 set mode no match");
        at_cnt(16'd10, 0);
        chk(ref_out, 1'b1, "R4 set mode on match");
        cnt_val = 16'd11;
        set_ctl(3'b010, 0, 0);
        at_cnt(16'd10, 0);
        chk(ref_out, 1'b0, "R4 clear mode on match");
        cnt_val = 16'd11;
        set_ctl(3'b011, 0, 0);
        at_cnt(16'd10, 0);
        chk(ref_out, 1'b1, "R4 toggle first");
        at_cnt(16'd10, 0);
        chk(ref_out, 1'b0, "R4 toggle second");
        at_cnt(16'd11, 0);
        chk(ref_out, 1'b0, "R4 toggle no match holds");

        // R5: PWM0 direction-aware
        cur_tag = "R5";
        set_ctl(3'b110, 0, 0);
        at_cnt(16'd9, 0);
        chk(ref_out, 1'b1, "R5 up below");
        at_cnt(16'd10, 0);
        chk(ref_out, 1'b0, "R5 up equal");
        at_cnt(16'd10, 1);
        chk(ref_out, 1'b1, "R5 down equal");
        at_cnt(16'd11, 1);
        chk(ref_out, 1'b0, "R5 down above");

        // R6: PWM1 inverse
        cur_tag = "R6";
        set_ctl(3'b111, 0, 0);
        at_cnt(16'd9, 0);
        chk(ref_out, 1'b0, "R6 up below");
        at_cnt(16'd10, 0);
        chk(ref_out, 1'b1, "R6 up equal");
        at_cnt(16'd10, 1);
        chk(ref_out, 1'b0, "R6 down equal");

        // R9 and R7: trigger force, fast then slow
        cur_tag = "R9";
        set_cv(16'd100);
        set_ctl(3'b111, 0, 1);
        at_cnt(16'd5, 0);
        chk(ref_out, 1'b0, "R9 idle before fast trigger");
        trig_edge = 1;
        cycle();
        chk(ref_out, 1'b0, "R9 fast edge k");
        cycle();
        chk(ref_out, 1'b0, "R9 fast edge k+1");
        cycle();
        chk(ref_out, 1'b1, "R9 fast edge k+2");
        cur_tag = "R7";
        at_cnt(16'd5, 0);
        at_cnt(16'd5, 0);
        chk(ref_out, 1'b1, "R7 forced level held");
        at_cnt(16'd100, 0);
        at_cnt(16'd5, 0);
        chk(ref_out, 1'b0, "R7 reloads on comparison change");
        cur_tag = "R9";
        set_ctl(3'b111, 0, 0);
        trig_edge = 1;
        cycle();
        chk(ref_out, 1'b0, "R9 slow edge k");
        cycle();
        cycle();
        chk(ref_out, 1'b0, "R9 slow edge k+2");
        cycle();
        chk(ref_out, 1'b0, "R9 slow edge k+3");
        cycle();
        chk(ref_out, 1'b1, "R9 slow edge k+4");

        // R8: shadowed compare value
        cur_tag = "R8";
        cnt_val = 16'd50;
        set_ctl(3'b110, 1, 0);
        at_cnt(16'd50, 0);
        chk(ref_out, 1'b1, "R8 old compare active");
        set_cv(16'd20);
        at_cnt(16'd50, 0);
        chk(ref_out, 1'b1, "R8 shadow write not yet active");
        upd_evt = 1;
        cycle();
        chk(ref_out, 1'b1, "R8 load edge uses old value");
        at_cnt(16'd50, 0);
        chk(ref_out, 1'b0, "R8 new value after update");

        // R12: protection lock
        cur_tag = "R12";
        prot_lvl = 2'b11;
        set_ctl(3'b101, 1, 0);
        at_cnt(16'd50, 0);
        chk(ref_out, 1'b0, "R12 locked mode write ignored");
        prot_lvl = 2'b00;
        set_ctl(3'b101, 0, 0);
        at_cnt(16'd50, 0);
        chk(ref_out, 1'b1, "R12 unlocked write accepted");

        // R11 and R10: I/O selection
        cur_tag = "R11";
        chan_en = 1;
        set_io(2'b01);
        at_cnt(16'd50, 0);
        chk(ref_out, 1'b1, "R11 io write blocked while enabled");
        chan_en = 0;
        cur_tag = "R10";
        set_io(2'b01);
        at_cnt(16'd50, 0);
        chk(ref_out, 1'b0, "R10 input mode output inactive");
        prot_lvl = 2'b11;
        set_ctl(3'b111, 0, 1);
        trig_edge = 1;
        cycle();
        cycle(); cycle(); cycle();
        chk(ref_out, 1'b0, "R10 trigger ignored in input mode");
        set_io(2'b00);
        at_cnt(16'd50, 0);
        chk(ref_out, 1'b1, "R12 write accepted while input selected");
        prot_lvl = 2'b00;

        // random phase checked against the model
        begin
            logic [W-1:0] c = '0;
            logic dn = 0;
            for (int i = 0; i < 4000; i++) begin
                if (!dn) begin
                    if (c >= 16'd63) dn = 1; else c = c + 1;
                end else begin
                    if (c == 0) dn = 0; else c = c - 1;
                end
                cnt_val = c; cnt_down = dn;
                if ($urandom_range(0, 19) == 0) begin
                    wr_ctl = 1;
                    ctl_mode = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 5))
                                                          : 3'($urandom_range(6, 7));
                    ctl_shadow_en = 1'($urandom_range(0, 1));
                    ctl_fast_en = 1'($urandom_range(0, 1));
                end
                if ($urandom_range(0, 15) == 0) begin
                    wr_cv = 1; cv_in = 16'($urandom_range(0, 70));
                end
                upd_evt   = ($urandom_range(0, 31) == 0);
                trig_edge = ($urandom_range(0, 23) == 0);
                if ($urandom_range(0, 99) == 0) prot_lvl = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 149) == 0) begin
                    chan_en = 1'($urandom_range(0, 1));
                    wr_iosel = 1;
                    iosel_in = ($urandom_range(0, 2) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
                end
                case (m_mode)
                    3'b110:  cur_tag = "R5";
                    3'b111:  cur_tag = "R6";
                    3'b000:  cur_tag = "R3";
                    3'b100, 3'b101: cur_tag = "R2";
                    default: cur_tag = "R4";
                endcase
                cycle();
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule